// File: doc/BRIEF.md
# Refill Credit Gate for Miss-Entry Capacity

This block sits between a pool of miss-status entries and the cache main pipeline. It tracks how many miss entries are free for new allocations, and it delays the moment a refilled entry counts as free. A refill's data is delivered at once by other logic. When a refill is an allocating read (demand or prefetch) that has a queue target, the block keeps the freed slot behind a credit. The slot becomes free again only when that refill finishes the last stage of the main pipeline.

Other responses skip the credit and free their entry in the same cycle. These are permission-only upgrades, whole-line write responses, and allocating reads with no target. The no-target reads are counted separately. A one-cycle unblock pulse tells the requesters to retry. It fires only when effective capacity actually returns after the pool was full. A refill that is moved into a credit while the pool is full does not fire it.

Top module: `refill_credit_gate`

## Requirements
- R1: After reset the effective free count equals NUM_ENTRIES. The full flag, unblock pulse, pipeline push strobe and both statistic counters are 0.
- R2: An allocation request lowers the effective free count by one on the next cycle when that count is above zero. When the count is zero the request is ignored.
- R3: A refill of kind 2'b00 (demand read) or 2'b01 (prefetch read) with a target takes a credit. The effective free count is unchanged, the push strobe is high for one cycle after the refill, and the admit counter goes up by one.
- R4: A pipeline completion strobe releases one held credit and raises the effective free count by one on the next cycle. A completion with no credit held has no effect.
- R5: A refill of kind 2'b10 (upgrade) or 2'b11 (whole-line write) frees its entry immediately. The effective free count rises by one, with no push strobe and no change to either counter.
- R6: A read refill (2'b00 or 2'b01) without a target frees its entry immediately. It raises the skip counter by one and takes no credit.
- R7: The unblock pulse is high for exactly one cycle, the first cycle in which the effective free count is above zero after a cycle where it was zero. It stays low when the only event during a full cycle is a credited refill.
- R8: Both statistic counters saturate at their all-ones value.
- R9: A refill response that arrives while no entry is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Request to allocate one miss entry |
| refill_valid_i | input | 1 | Refill response frees one outstanding entry |
| refill_kind_i | input | 2 | 00 demand read, 01 prefetch read, 10 upgrade, 11 whole-line write |
| refill_has_tgt_i | input | 1 | Refill has a load/store-queue target |
| pipe_done_i | input | 1 | A credited refill has completed the last pipeline stage |
| eff_free_o | output | $clog2(NUM_ENTRIES+1) | Effective free entry count |
| full_o | output | 1 | Effective free count is zero |
| unblock_o | output | 1 | Retry pulse on real capacity return |
| pipe_push_o | output | 1 | A credited refill entered the pipeline last cycle |
| admit_cnt_o | output | CNT_W | Saturating count of credited refills |
| skip_cnt_o | output | CNT_W | Saturating count of no-target read refills |

## Verification
The assertions assume the completion strobe never arrives more often than credits were taken. They also assume the environment sends at most one refill per cycle, and they assume every input is low during reset. The stimulus keeps the inputs low through reset and drives only one refill or completion event per cycle. It issues completions both with credits held and with none held, so that the ignore path (R4) is tested on purpose and not by accident. Allocations are tried when the pool is full, and refills are tried with no entry outstanding. This shows that the gating keeps the internal counts inside the bounds the assertions check.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic [1:0] {
    RK_DEMAND   = 2'b00,
    RK_PREFETCH = 2'b01,
    RK_UPGRADE  = 2'b10,
    RK_LINE_WR  = 2'b11
  } refill_kind_e;

  // True for allocating read refills, the only kinds that may enter the pipe.
  function automatic logic kind_is_read(input logic [1:0] kind);
    return (kind == RK_DEMAND) || (kind == RK_PREFETCH);
  endfunction

  // Effective free entries: total minus outstanding minus held credits.
  function automatic int calc_eff_free(input int total, input int used, input int held);
    int r;
    r = total - used - held;
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/rcg_classify.sv
module rcg_classify
  import rcg_pkg::*;
(
  input  logic       refill_valid_i,
  input  logic [1:0] refill_kind_i,
  input  logic       refill_has_tgt_i,
  input  logic       outstanding_i,
  output logic       refill_ok_o,
  output logic       hold_evt_o,
  output logic       skip_evt_o,
  output logic       bypass_evt_o
);

  logic is_read;

  always_comb begin
    is_read      = kind_is_read(refill_kind_i);
    refill_ok_o  = refill_valid_i && outstanding_i;
    hold_evt_o   = refill_ok_o && is_read && refill_has_tgt_i;
    skip_evt_o   = refill_ok_o && is_read && !refill_has_tgt_i;
    bypass_evt_o = refill_ok_o && !is_read;
  end

endmodule

// File: rtl/rcg_credit.sv
module rcg_credit #(
  parameter int NUM_ENTRIES = 8,
  localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_evt_i,
  input  logic          pipe_done_i,
  output logic          release_evt_o,
  output logic [CW-1:0] credit_o
);

  localparam logic [CW-1:0] MAX_C = CW'(NUM_ENTRIES);

  logic [CW-1:0] credit_q;

  assign release_evt_o = pipe_done_i && (credit_q != '0);
  assign credit_o      = credit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else begin
      case ({hold_evt_i, release_evt_o})
        2'b10:   credit_q <= credit_q + 1'b1;
        2'b01:   credit_q <= credit_q - 1'b1;
        default: credit_q <= credit_q;
      endcase
    end
  end

  assert_credit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= MAX_C);

  assert_drop_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_q < $past(credit_q)) |-> $past(pipe_done_i));

endmodule

// File: rtl/rcg_occupancy.sv
module rcg_occupancy #(
  parameter int NUM_ENTRIES = 8,
  localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic          room_i,
  input  logic          free_evt_i,
  output logic          alloc_ok_o,
  output logic          outstanding_o,
  output logic [CW-1:0] in_use_o
);

  localparam logic [CW-1:0] MAX_C = CW'(NUM_ENTRIES);

  logic [CW-1:0] in_use_q;

  assign alloc_ok_o    = alloc_i && room_i;
  assign outstanding_o = (in_use_q != '0);
  assign in_use_o      = in_use_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_use_q <= '0;
    end else begin
      case ({alloc_ok_o, free_evt_i})
        2'b10:   in_use_q <= in_use_q + 1'b1;
        2'b01:   in_use_q <= in_use_q - 1'b1;
        default: in_use_q <= in_use_q;
      endcase
    end
  end

  assert_blocked_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alloc_i && !room_i && !free_evt_i) |-> (in_use_q == $past(in_use_q)));

  assert_in_use_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_use_q <= MAX_C);

endmodule

// File: rtl/rcg_satcnt.sv
module rcg_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] value_o
);

  logic [W-1:0] val_q;

  assign value_o = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  val_q <= '0;
    else if (inc_i && !(&val_q)) val_q <= val_q + 1'b1;
  end

  assert_saturate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&val_q) |=> (&val_q));

endmodule

// File: rtl/refill_credit_gate.sv
module refill_credit_gate
  import rcg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CNT_W       = 16,
  localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             refill_valid_i,
  input  logic [1:0]       refill_kind_i,
  input  logic             refill_has_tgt_i,
  input  logic             pipe_done_i,
  output logic [CW-1:0]    eff_free_o,
  output logic             full_o,
  output logic             unblock_o,
  output logic             pipe_push_o,
  output logic [CNT_W-1:0] admit_cnt_o,
  output logic [CNT_W-1:0] skip_cnt_o
);

  // Named internal events, visible to assertions.
  logic          refill_ok, hold_evt, skip_evt, bypass_evt;
  logic          free_evt, release_evt, alloc_ok, outstanding;
  logic [CW-1:0] credit, in_use;
  logic          unblock_q, push_q;

  assign free_evt = refill_ok;

  rcg_classify u_classify (
    .refill_valid_i   (refill_valid_i),
    .refill_kind_i    (refill_kind_i),
    .refill_has_tgt_i (refill_has_tgt_i),
    .outstanding_i    (outstanding),
    .refill_ok_o      (refill_ok),
    .hold_evt_o       (hold_evt),
    .skip_evt_o       (skip_evt),
    .bypass_evt_o     (bypass_evt)
  );

  rcg_occupancy #(.NUM_ENTRIES(NUM_ENTRIES)) u_occupancy (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_i       (alloc_i),
    .room_i        (!full_o),
    .free_evt_i    (free_evt),
    .alloc_ok_o    (alloc_ok),
    .outstanding_o (outstanding),
    .in_use_o      (in_use)
  );

  rcg_credit #(.NUM_ENTRIES(NUM_ENTRIES)) u_credit (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_evt_i    (hold_evt),
    .pipe_done_i   (pipe_done_i),
    .release_evt_o (release_evt),
    .credit_o      (credit)
  );

  // Statistics: index 0 admitted refills, index 1 skipped refills.
  logic [1:0]       stat_inc;
  logic [CNT_W-1:0] stat_val [2];

  assign stat_inc = {skip_evt, hold_evt};

  for (genvar g = 0; g < 2; g++) begin : g_stat
    rcg_satcnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (stat_inc[g]),
      .value_o (stat_val[g])
    );
  end

  assign admit_cnt_o = stat_val[0];
  assign skip_cnt_o  = stat_val[1];

  // Effective capacity seen by requesters.
  always_comb begin
    eff_free_o = CW'(calc_eff_free(NUM_ENTRIES, int'(in_use), int'(credit)));
    full_o     = (eff_free_o == '0);
  end

  // Full is sampled before the credit is taken: an event that raises
  // effective capacity during a full cycle triggers the retry pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unblock_q <= 1'b0;
      push_q    <= 1'b0;
    end else begin
      unblock_q <= full_o && (release_evt || skip_evt || bypass_evt);
      push_q    <= hold_evt;
    end
  end

  assign unblock_o   = unblock_q;
  assign pipe_push_o = push_q;

  assert_unblock_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_o |-> ($past(full_o) && !full_o));

  assert_unblock_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unblock_o |=> !unblock_o);

  assert_bypass_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(refill_valid_i && refill_kind_i[1]) |-> !pipe_push_o);

  assert_push_needs_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_push_o |-> $past(refill_has_tgt_i && refill_valid_i));

endmodule

// File: tb/test_refill_credit_gate.sv
module test_refill_credit_gate;

  localparam int N  = 4;
  localparam int CNTW = 3;
  localparam int CW = $clog2(N + 1);
  localparam int CMAX = (1 << CNTW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc = 1'b0, rv = 1'b0, tgt = 1'b0, done = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [CW-1:0] eff;
  logic full, unbl, push;
  logic [CNTW-1:0] adm, skp;

  always #4 clk = ~clk;  // 125 MHz

  refill_credit_gate #(.NUM_ENTRIES(N), .CNT_W(CNTW)) i_refill_credit_gate (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .refill_valid_i(rv),
    .refill_kind_i(kind), .refill_has_tgt_i(tgt), .pipe_done_i(done),
    .eff_free_o(eff), .full_o(full), .unblock_o(unbl), .pipe_push_o(push),
    .admit_cnt_o(adm), .skip_cnt_o(skp)
  );

  typedef struct {
    int eff; int full; int unbl; int push; int adm; int skp; string req;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  // Reference state.
  int m_used = 0, m_held = 0, m_adm = 0, m_skp = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome.
  task automatic cyc(input string req, input bit a, input bit r, input logic [1:0] k,
                     input bit t, input bit d);
    int eff0, eff1;
    bit rok, rd, hold, skip, dok, aok;
    exp_t e;
    @(negedge clk);
    alloc = a; rv = r; kind = k; tgt = t; done = d;
    eff0 = N - m_used - m_held;
    aok  = a && (eff0 > 0);
    rok  = r && (m_used > 0);
    rd   = (k == 2'b00) || (k == 2'b01);
    hold = rok && rd && t;
    skip = rok && rd && !t;
    dok  = d && (m_held > 0);
    m_used = m_used + int'(aok) - int'(rok);
    m_held = m_held + int'(hold) - int'(dok);
    if (hold && m_adm < CMAX) m_adm++;
    if (skip && m_skp < CMAX) m_skp++;
    eff1 = N - m_used - m_held;
    e.eff = eff1; e.full = (eff1 == 0); e.unbl = (eff0 == 0) && (eff1 > 0);
    e.push = hold; e.adm = m_adm; e.skp = m_skp; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 0, 2'b00, 0, 0);
  endtask

  // Monitor: compare design outputs against queued expectations.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "eff_free", int'(eff), e.eff);
        check(e.req, "full", int'(full), e.full);
        check(e.req, "unblock", int'(unbl), e.unbl);
        check(e.req, "push", int'(push), e.push);
        check(e.req, "admit", int'(adm), e.adm);
        check(e.req, "skip", int'(skp), e.skp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", "eff_free", int'(eff), N);
    check("R1", "full", int'(full), 0);
    check("R1", "unblock", int'(unbl), 0);
    check("R1", "push", int'(push), 0);
    check("R1", "admit", int'(adm), 0);
    check("R1", "skip", int'(skp), 0);

    cyc("R2", 1, 0, 2'b00, 0, 0);
    cyc("R2", 1, 0, 2'b00, 0, 0);
    cyc("R3", 0, 1, 2'b00, 1, 0);   // demand read with target
    cyc("R3", 0, 1, 2'b01, 1, 0);   // prefetch read with target
    cyc("R9", 0, 1, 2'b10, 0, 0);   // nothing outstanding
    cyc("R4", 0, 0, 2'b00, 0, 1);
    cyc("R4", 0, 0, 2'b00, 0, 1);
    cyc("R4", 0, 0, 2'b00, 0, 1);   // no credit held: ignored
    for (int i = 0; i < N; i++) cyc("R2", 1, 0, 2'b00, 0, 0);
    cyc("R2", 1, 0, 2'b00, 0, 0);   // full: ignored
    cyc("R5", 0, 1, 2'b10, 1, 0);   // upgrade while full -> unblock
    idle("R7");
    cyc("R2", 1, 0, 2'b00, 0, 0);
    cyc("R7", 0, 1, 2'b00, 1, 0);   // credited while full: no unblock
    idle("R7");
    cyc("R7", 0, 0, 2'b00, 0, 1);   // release while full -> unblock
    idle("R7");
    cyc("R6", 0, 1, 2'b01, 0, 0);   // read without target
    cyc("R6", 0, 1, 2'b00, 0, 0);
    cyc("R5", 0, 1, 2'b11, 0, 0);   // whole-line write
    for (int i = 0; i < CMAX + 3; i++) begin
      cyc("R8", 1, 0, 2'b00, 0, 0);
      cyc("R8", 0, 1, 2'b01, 1, 0);
      cyc("R8", 0, 0, 2'b00, 0, 1);
      cyc("R8", 1, 0, 2'b00, 0, 0);
      cyc("R8", 0, 1, 2'b00, 0, 0);
    end
    idle("R1");
    idle("R1");
    repeat (2) @(negedge clk);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule